// File: doc/BRIEF.md
# Banked Internal Data Memory Address Mapper

This block turns the operand specifiers of an 8-bit controller into accesses on its internal data storage. That storage has three parts: a lower 128-byte RAM, an upper 128-byte RAM, and a special-function-register window. The kind of access chooses where the upper half of the address range lands. A direct access to 80h–FFh reaches the register window. An indirect or stack access to the same range reaches the upper RAM. Register operands pick one of four 8-byte banks at the bottom of the lower RAM, using two bank-select bits sampled in the same cycle.

Single-bit operands have their own 256-bit address space. The low half of that space is carried by bytes 20h–2Fh of the lower RAM. The high half is carried by the register-window bytes whose address ends in three zero bits. A set, clear or complement is done as one read-modify-write in the cycle of the operation.

The stack pointer is the only register kept in the window. It resets to 07h, grows upward, and is reachable at direct address 81h. All other register-window accesses are only flagged on the select strobe; their storage lies outside the block. Read data is combinational from the inputs of the current cycle, and every update happens on the rising clock edge that ends the cycle.

Top module: `idata_mapper`

## Requirements
- R1: After reset the stack pointer is 07h; a direct read of 81h returns it, and a direct write to 81h replaces it.
- R2: A register access (kind 0) with bank bits b and index spec[2:0] reaches lower-RAM byte 8*b + index.
- R3: A direct access (kind 1) or indirect access (kind 2) below 80h reaches the same lower-RAM byte.
- R4: A direct access to 80h–FFh raises sfr_sel and touches no RAM byte; apart from 81h, such reads return 00h.
- R5: An indirect access to 80h–FFh reaches the upper RAM with sfr_sel low.
- R6: A bit access (kind 4) to bit address 00h–7Fh uses lower-RAM byte 20h + spec[6:3] and bit spec[2:0]. Op 3 sets the bit, op 4 clears it and op 5 complements it, and the other seven bits keep their values. In any bit access, rd_data bit 0 carries the bit's value before the update and bits 7:1 are zero.
- R7: A bit access to 80h–FFh raises sfr_sel and leaves every RAM byte unchanged.
- R8: A stack write (kind 3, op 2) first increments the stack pointer and then stores at the new value. A stack read (kind 3, op 1) returns the byte at the stack pointer and then decrements it.
- R9: Stack bytes above 7Fh go to the upper RAM and never raise sfr_sel.
- R10: With UPPER_EN = 0, writes to the upper range are dropped and reads there return 00h, while lower-RAM accesses still work.
- R11: Op 0 is idle: no storage changes and sfr_sel stays low. Op 1 reads and op 2 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the stack pointer |
| acc_kind | input | 3 | 0 register, 1 direct, 2 indirect, 3 stack, 4 bit |
| spec | input | 8 | Operand specifier (address, register index or bit address) |
| bank_sel | input | 2 | Register bank for register accesses |
| wr_data | input | 8 | Byte to store |
| op | input | 3 | 0 idle, 1 read, 2 write, 3 set bit, 4 clear bit, 5 complement bit |
| rd_data | output | 8 | Byte read, or the old bit value in bit 0 for bit accesses |
| sfr_sel | output | 1 | High while the access targets the register window |

## Verification
The bench uses the same numeric address through different access kinds. A direct write and an indirect read of 90h must not meet; a mapper that ignored the kind would let the direct write land in the upper RAM. Bit operations are run on a byte that already holds other set bits, so that a wrong byte offset or a whole-byte overwrite would change a neighbouring bit. A stack that crosses 7Fh must land in the upper RAM, and the stack must write only after the increment; the wrong order would leave the pushed byte one location low. A second instance without upper RAM must drop those writes and return zero, rather than folding them onto the lower RAM.

// File: rtl/idata_mapper.sv
module idata_mapper #(
  parameter int UPPER_EN = 1,
  parameter logic [7:0] SP_RESET = 8'h07,
  parameter logic [7:0] SP_ADDR = 8'h81
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] acc_kind,
  input  logic [7:0] spec,
  input  logic [1:0] bank_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] op,
  output logic [7:0] rd_data,
  output logic       sfr_sel
);
  localparam int HALF = 128;

  logic [7:0] lo_mem [HALF];
  logic [7:0] sp;
  logic       in_lo, in_hi, is_sfr;
  logic [6:0] idx;
  logic [7:0] win_addr;
  logic [7:0] cur, hi_rd, new_byte;
  logic [2:0] bitn;
  logic       active, is_bitop, do_wr, push, pop;

  assign active   = op != 3'd0;
  assign is_bitop = acc_kind == 3'd4 && (op == 3'd3 || op == 3'd4 || op == 3'd5);
  assign push     = acc_kind == 3'd3 && op == 3'd2;
  assign pop      = acc_kind == 3'd3 && op == 3'd1;
  assign bitn     = spec[2:0];

  always_comb begin
    in_lo = 1'b0; in_hi = 1'b0; is_sfr = 1'b0;
    idx = spec[6:0]; win_addr = spec;
    case (acc_kind)
      3'd0: begin in_lo = 1'b1; idx = {2'b00, bank_sel, spec[2:0]}; end
      3'd1: begin is_sfr = spec[7]; in_lo = ~spec[7]; end
      3'd2: begin in_hi = spec[7]; in_lo = ~spec[7]; end
      3'd3: begin
        win_addr = push ? sp + 8'd1 : sp;
        idx = win_addr[6:0];
        in_hi = win_addr[7]; in_lo = ~win_addr[7];
      end
      3'd4: begin
        is_sfr = spec[7];
        in_lo = ~spec[7];
        idx = {3'b010, spec[6:3]};
        win_addr = {spec[7:3], 3'b000};
      end
      default: ;
    endcase
  end

  always_comb begin
    if (in_lo) cur = lo_mem[idx];
    else if (in_hi) cur = hi_rd;
    else if (is_sfr && win_addr == SP_ADDR) cur = sp;
    else cur = 8'h00;
  end

  always_comb begin
    new_byte = wr_data;
    if (is_bitop) begin
      new_byte = cur;
      case (op)
        3'd3: new_byte[bitn] = 1'b1;
        3'd4: new_byte[bitn] = 1'b0;
        default: new_byte[bitn] = ~cur[bitn];
      endcase
    end
  end

  assign do_wr   = is_bitop || (op == 3'd2 && acc_kind != 3'd4);
  assign rd_data = (acc_kind == 3'd4) ? {7'd0, cur[bitn]} : cur;
  assign sfr_sel = is_sfr && active;

  always_ff @(posedge clk)
    if (do_wr && in_lo) lo_mem[idx] <= new_byte;

  generate
    if (UPPER_EN != 0) begin : g_upper
      logic [7:0] hi_mem [HALF];
      always_ff @(posedge clk)
        if (do_wr && in_hi) hi_mem[idx] <= new_byte;
      assign hi_rd = hi_mem[idx];
    end else begin : g_no_upper
      assign hi_rd = 8'h00;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sp <= SP_RESET;
    else if (push) sp <= sp + 8'd1;
    else if (pop) sp <= sp - 8'd1;
    else if (acc_kind == 3'd1 && op == 3'd2 && spec == SP_ADDR) sp <= wr_data;

  a_r8_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 3'd3 && op == 3'd2) |=> sp == $past(sp) + 8'd1);
  a_r8_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 3'd3 && op == 3'd1) |=> sp == $past(sp) - 8'd1);
  a_r9_stack_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 3'd3 |-> !sfr_sel);
  a_r5_indirect_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_kind == 3'd2 |-> !sfr_sel);
  a_r11_idle_holds_sp: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 |=> $stable(sp));
  a_r11_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 |-> !sfr_sel);
  a_r6_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 3'd4 && op == 3'd3 && !spec[7]) |=> rd_data[0] == 1'b1 || acc_kind != 3'd4 || spec != $past(spec));
endmodule

// File: tb/idata_mapper_bench.sv
module idata_mapper_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] acc_kind = 3'd0, op = 3'd0;
  logic [7:0] spec = 8'h00, wr_data = 8'h00;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] rd_a, rd_b;
  logic sel_a, sel_b;
  int n_chk = 0, n_bad = 0;
  logic [7:0] got, got_b;
  logic gsel, gsel_b;

  always #10 clk = ~clk;

  idata_mapper u_idata_mapper (.clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .spec(spec),
    .bank_sel(bank_sel), .wr_data(wr_data), .op(op), .rd_data(rd_a), .sfr_sel(sel_a));
  idata_mapper #(.UPPER_EN(0)) u_idata_mapper_nu (.clk(clk), .rst_n(rst_n), .acc_kind(acc_kind),
    .spec(spec), .bank_sel(bank_sel), .wr_data(wr_data), .op(op), .rd_data(rd_b), .sfr_sel(sel_b));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] k, input logic [7:0] s, input logic [1:0] b,
                     input logic [7:0] d, input logic [2:0] o);
    @(negedge clk);
    acc_kind = k; spec = s; bank_sel = b; wr_data = d; op = o;
    #2;
    got = rd_a; gsel = sel_a; got_b = rd_b; gsel_b = sel_b;
    @(posedge clk); #1;
    op = 3'd0;
  endtask

  task automatic t_reset;
    acc(3'd1, 8'h81, 2'd0, 8'h00, 3'd1);
    chk("R1 sp reset", got, 8'h07);
    chk("R4 sel on 81h", {7'd0, gsel}, 8'h01);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 4; b++) acc(3'd0, 8'h05, b[1:0], 8'h50 + 8'(b), 3'd2);
    for (int b = 0; b < 4; b++) begin
      acc(3'd2, 8'(b * 8 + 5), 2'd0, 8'h00, 3'd1);
      chk("R2 bank map", got, 8'h50 + 8'(b));
    end
    acc(3'd1, 8'h10, 2'd0, 8'hE1, 3'd2);
    acc(3'd0, 8'h00, 2'd2, 8'h00, 3'd1);
    chk("R2 bank2 r0", got, 8'hE1);
  endtask

  task automatic t_dir_ind;
    acc(3'd1, 8'h45, 2'd0, 8'hA5, 3'd2);
    acc(3'd2, 8'h45, 2'd0, 8'h00, 3'd1);
    chk("R3 direct to indirect", got, 8'hA5);
    acc(3'd2, 8'h90, 2'd0, 8'h3C, 3'd2);
    chk("R5 indirect sel low", {7'd0, gsel}, 8'h00);
    acc(3'd1, 8'h90, 2'd0, 8'hFF, 3'd2);
    chk("R4 direct sel high", {7'd0, gsel}, 8'h01);
    acc(3'd1, 8'h90, 2'd0, 8'h00, 3'd1);
    chk("R4 direct read zero", got, 8'h00);
    acc(3'd2, 8'h90, 2'd0, 8'h00, 3'd1);
    chk("R5 upper kept", got, 8'h3C);
  endtask

  task automatic t_bits;
    acc(3'd1, 8'h25, 2'd0, 8'h41, 3'd2);
    acc(3'd4, 8'h2B, 2'd0, 8'h00, 3'd3);
    chk("R6 old bit", got, 8'h00);
    acc(3'd1, 8'h25, 2'd0, 8'h00, 3'd1);
    chk("R6 set", got, 8'h49);
    acc(3'd4, 8'h2F, 2'd0, 8'h00, 3'd5);
    acc(3'd1, 8'h25, 2'd0, 8'h00, 3'd1);
    chk("R6 complement", got, 8'hC9);
    acc(3'd4, 8'h28, 2'd0, 8'h00, 3'd4);
    chk("R6 old bit one", got, 8'h01);
    acc(3'd1, 8'h25, 2'd0, 8'h00, 3'd1);
    chk("R6 clear", got, 8'hC8);
    acc(3'd4, 8'h2F, 2'd0, 8'h00, 3'd1);
    chk("R6 bit read", got, 8'h01);
  endtask

  task automatic t_sfr_bit;
    acc(3'd2, 8'h80, 2'd0, 8'h55, 3'd2);
    acc(3'd4, 8'h83, 2'd0, 8'h00, 3'd3);
    chk("R7 sel", {7'd0, gsel}, 8'h01);
    acc(3'd2, 8'h80, 2'd0, 8'h00, 3'd1);
    chk("R7 upper untouched", got, 8'h55);
    acc(3'd2, 8'h10, 2'd0, 8'h00, 3'd1);
    chk("R7 lower untouched", got, 8'hE1);
  endtask

  task automatic t_stack;
    acc(3'd1, 8'h81, 2'd0, 8'h30, 3'd2);
    acc(3'd3, 8'h00, 2'd0, 8'h11, 3'd2);
    acc(3'd3, 8'h00, 2'd0, 8'h22, 3'd2);
    acc(3'd1, 8'h81, 2'd0, 8'h00, 3'd1);
    chk("R8 sp after pushes", got, 8'h32);
    acc(3'd2, 8'h31, 2'd0, 8'h00, 3'd1);
    chk("R8 first push slot", got, 8'h11);
    acc(3'd3, 8'h00, 2'd0, 8'h00, 3'd1);
    chk("R8 pop top", got, 8'h22);
    acc(3'd3, 8'h00, 2'd0, 8'h00, 3'd1);
    chk("R8 pop next", got, 8'h11);
    acc(3'd3, 8'h00, 2'd0, 8'h00, 3'd0);
    acc(3'd1, 8'h81, 2'd0, 8'h00, 3'd1);
    chk("R11 idle keeps sp", got, 8'h30);
    acc(3'd1, 8'h81, 2'd0, 8'h7F, 3'd2);
    acc(3'd3, 8'h00, 2'd0, 8'h99, 3'd2);
    chk("R9 push sel low", {7'd0, gsel}, 8'h00);
    acc(3'd2, 8'h80, 2'd0, 8'h00, 3'd1);
    chk("R9 push in upper", got, 8'h99);
    chk("R10 lost push", got_b, 8'h00);
    acc(3'd3, 8'h00, 2'd0, 8'h00, 3'd1);
    chk("R9 pop from upper", got, 8'h99);
  endtask

  task automatic t_no_upper;
    acc(3'd2, 8'hC0, 2'd0, 8'h77, 3'd2);
    acc(3'd2, 8'hC0, 2'd0, 8'h00, 3'd1);
    chk("R10 upper read zero", got_b, 8'h00);
    chk("R10 ref has upper", got, 8'h77);
    acc(3'd2, 8'h12, 2'd0, 8'h6A, 3'd2);
    acc(3'd2, 8'h12, 2'd0, 8'h00, 3'd1);
    chk("R10 lower works", got_b, 8'h6A);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_banks();
    t_dir_ind();
    t_bits();
    t_sfr_bit();
    t_stack();
    t_no_upper();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule